// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between the fetch stage and the execute stage of a two-stage processor pipeline. It holds up to six instruction bytes. It requests 16-bit words from memory whenever it has room for a whole word, and it keeps doing so while the execute stage is stalled on a long instruction. The execute stage can then take one or two bytes per cycle straight from storage, with no memory wait, whenever enough bytes are present. Because fetching runs on its own, decoding of the next instruction can overlap with the end of the current one.

The memory side uses a plain request/response handshake with at most one read outstanding. A request names a word-aligned address. The matching response carries the byte at the even address in bits 7:0 and the byte at the odd address in bits 15:8. A control transfer is signalled by a one-cycle flush with a new target address. The flush empties the queue, restarts fetching at the target and discards any response that was still in flight. If the target is odd, only the upper byte of the first word is kept.

Top module: `ifetch_queue`

## Requirements
- R1: The stored byte count `q_count` never exceeds DEPTH (default 6).
- R2: A synchronous active-low reset empties the queue and sets the fetch address to RESET_VEC. In the first cycle after reset, `mem_req` is high and `mem_addr` equals RESET_VEC with bit 0 cleared.
- R3: `mem_req` is raised only when no read is outstanding and at least two byte slots are free (`q_count` <= DEPTH-2). `mem_addr` is always the fetch address with bit 0 forced to 0.
- R4: With no pops and an even fetch address, fetching continues until the queue holds DEPTH bytes. `mem_req` then stays low.
- R5: A kept response enters the queue as `mem_rdata[7:0]` first and `mem_rdata[15:8]` second, so bytes leave the queue in ascending address order.
- R6: `pop_data[7:0]` is always the oldest stored byte and `pop_data[15:8]` is the next one. A pop with `pop_two`=0 removes one byte and a pop with `pop_two`=1 removes two. The bytes are valid in the same cycle as the pop.
- R7: `pop_ready` is high exactly when `q_count` is at least 1 (`pop_two`=0) or at least 2 (`pop_two`=1). A `pop_req` while `pop_ready` is low removes nothing.
- R8: When `flush` is high, no pop is taken in that cycle. The queue is empty in the next cycle, and the next request and the next popped byte come from `flush_addr`.
- R9: A response for a read issued before or in a flush cycle is dropped and never enters the queue.
- R10: After a flush to an odd address, the first kept response adds only its upper byte (`mem_rdata[15:8]`), and fetching goes on at the next even address.
- R11: A push and a pop in the same cycle are both performed, and `q_count` changes by bytes pushed minus bytes popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Control transfer: empty the queue and redirect fetching |
| flush_addr | input | AW | Byte address to fetch from after a flush |
| pop_req | input | 1 | Execute stage wants bytes this cycle |
| pop_two | input | 1 | 0: one byte wanted, 1: two bytes wanted |
| pop_ready | output | 1 | Enough bytes are stored for the requested pop size |
| pop_data | output | 16 | Oldest byte in [7:0], next byte in [15:8] |
| q_count | output | $clog2(DEPTH+1) | Number of bytes stored |
| mem_req | output | 1 | Word read request, accepted in the cycle it is high |
| mem_addr | output | AW | Word-aligned read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 16 | Read response, even-address byte in [7:0] |

## Verification
The hardest case to reach is a flush that arrives while a read is still outstanding. The response then comes back one or more cycles later, after the queue has already been redirected, and it must be dropped. A close relative is a flush in the very cycle a request is issued or a response returns. The bench gives the memory model a random latency of one to four cycles. In one phase it flushes only while a response is pending, and elsewhere it mixes in random flushes, including some to odd targets. It follows every popped byte against a byte-address stream that restarts at each target, so a stale word that slips through shows up as a byte mismatch.

// File: rtl/ifq_pkg.sv
// Package: ifq_pkg
// Types shared by the prefetch queue modules.
// Assumes at most two bytes move in either direction in one cycle.
package ifq_pkg;

    // One instruction byte.
    typedef logic [7:0] ifq_byte_t;

    // Number of bytes moved in a cycle; the encoding equals the count.
    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_ONE  = 2'd1,
        XFER_TWO  = 2'd2
    } ifq_xfer_e;

endpackage

// File: rtl/ifq_fetch.sv
// Module: ifq_fetch
// Tracks the fetch address and issues word reads, one at a time.
// Turns each kept response into one or two bytes to push.
// Assumes: the storage reports room for a full word; responses arrive in order,
// at least one cycle after their request; flush has priority over a response.
module ifq_fetch
    import ifq_pkg::*;
#(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] RESET_VEC = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic [AW-1:0] flush_addr,
    input  logic      room_ok,
    input  logic      rsp_valid,
    input  logic [15:0] rsp_word,
    output logic      rd_req,
    output logic [AW-1:0] rd_addr,
    output ifq_xfer_e push_kind,
    output ifq_byte_t push_b0,
    output ifq_byte_t push_b1
);

    localparam logic [AW-1:0] STEP_ONE = AW'(1);
    localparam logic [AW-1:0] STEP_TWO = AW'(2);

    logic [AW-1:0] fetch_pc;
    logic          busy;
    logic          drop;
    logic          issue;
    logic          take;
    logic          odd_pc;

    // Decide on issue and acceptance from the current state only.
    always_comb begin
        odd_pc = fetch_pc[0];
        issue  = rst_n & ~busy & room_ok;
        take   = busy & rsp_valid & ~drop & ~flush;
    end

    // Drive the request address (bit 0 cleared) and the request strobe.
    always_comb begin
        rd_req  = issue;
        rd_addr = {fetch_pc[AW-1:1], 1'b0};
    end

    // Pick the bytes a kept response contributes.
    always_comb begin
        if (!take)       push_kind = XFER_NONE;
        else if (odd_pc) push_kind = XFER_ONE;
        else             push_kind = XFER_TWO;
        push_b0 = odd_pc ? rsp_word[15:8] : rsp_word[7:0];
        push_b1 = rsp_word[15:8];
    end

    // Outstanding-read flag: set on issue, cleared when its response arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (issue)     busy <= 1'b1;
        else if (rsp_valid) busy <= 1'b0;
    end

    // Drop flag: marks the outstanding read as stale after a flush.
    always_ff @(posedge clk) begin
        if (!rst_n)         drop <= 1'b0;
        else if (flush)     drop <= (busy & ~rsp_valid) | issue;
        else if (rsp_valid) drop <= 1'b0;
    end

    // Fetch address: redirected by flush, advanced by the bytes pushed.
    always_ff @(posedge clk) begin
        if (!rst_n)     fetch_pc <= RESET_VEC;
        else if (flush) fetch_pc <= flush_addr;
        else if (take)  fetch_pc <= fetch_pc + (odd_pc ? STEP_ONE : STEP_TWO);
    end

endmodule

// File: rtl/ifq_store.sv
// Module: ifq_store
// Circular byte storage of DEPTH slots: pushes up to two bytes and pops up to
// two bytes per cycle, and shows the two oldest bytes without delay.
// Assumes: callers never push beyond free space or pop beyond the count;
// clr is never high together with a push.
module ifq_store
    import ifq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  ifq_xfer_e push_kind,
    input  ifq_byte_t push_b0,
    input  ifq_byte_t push_b1,
    input  ifq_xfer_e pop_kind,
    output ifq_byte_t head0,
    output ifq_byte_t head1,
    output logic [CW-1:0] count,
    output logic      room_ok
);

    localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - 2);

    ifq_byte_t     slot [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_nxt1;
    logic [PW-1:0] rd_nxt1;
    logic [1:0]    push_n;
    logic [1:0]    pop_n;

    // Advance a pointer by k slots, wrapping at DEPTH.
    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input logic [1:0] k);
        int unsigned s;
        s = int'(p) + int'(k);
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    // Neighbour pointers and transfer sizes.
    always_comb begin
        push_n  = push_kind;
        pop_n   = pop_kind;
        wr_nxt1 = wrap_add(wr_ptr, 2'd1);
        rd_nxt1 = wrap_add(rd_ptr, 2'd1);
    end

    // Head bytes and space flag.
    always_comb begin
        head0   = slot[rd_ptr];
        head1   = slot[rd_nxt1];
        room_ok = (count <= ROOM_LIMIT);
    end

    // Slot writes: the first byte goes to the write pointer, the second to the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_n != 2'd0 && wr_ptr == PW'(i))
                    slot[i] <= push_b0;
                else if (push_n == 2'd2 && wr_nxt1 == PW'(i))
                    slot[i] <= push_b1;
            end
        end
    end

    // Pointers and count: cleared by flush, otherwise moved by push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wrap_add(wr_ptr, push_n);
            rd_ptr <= wrap_add(rd_ptr, pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

endmodule

// File: rtl/ifq_drain.sv
// Module: ifq_drain
// Pop control for the execute side: decides whether the requested one or two
// bytes are present and turns an accepted request into a pop size.
// Assumes: a flush in the same cycle takes priority and suppresses the pop.
module ifq_drain
    import ifq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          pop_req,
    input  logic          pop_two,
    input  logic          flush,
    input  logic [CW-1:0] count,
    output logic          pop_ready,
    output ifq_xfer_e     pop_kind
);

    logic [CW-1:0] need;

    // Compare the stored count with the requested size and grant the pop.
    always_comb begin
        need      = pop_two ? CW'(2) : CW'(1);
        pop_ready = (count >= need);
        if (!pop_req || !pop_ready || flush) pop_kind = XFER_NONE;
        else if (pop_two)                    pop_kind = XFER_TWO;
        else                                 pop_kind = XFER_ONE;
    end

endmodule

// File: rtl/ifetch_queue.sv
// Module: ifetch_queue
// Instruction prefetch byte queue: fetches 16-bit words ahead of execution into
// DEPTH byte slots and hands one or two bytes per cycle to the execute stage.
// Assumes: DEPTH >= 2; memory keeps at most one read outstanding and answers in order.
module ifetch_queue
    import ifq_pkg::*;
#(
    parameter int            DEPTH     = 6,
    parameter int            AW        = 16,
    parameter logic [AW-1:0] RESET_VEC = 16'h0100,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          pop_req,
    input  logic          pop_two,
    output logic          pop_ready,
    output logic [15:0]   pop_data,
    output logic [CW-1:0] q_count,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [15:0]   mem_rdata
);

    ifq_xfer_e push_kind;
    ifq_xfer_e pop_kind;
    ifq_byte_t push_b0;
    ifq_byte_t push_b1;
    ifq_byte_t head0;
    ifq_byte_t head1;
    logic      room_ok;

    ifq_fetch #(.AW(AW), .RESET_VEC(RESET_VEC)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_addr (flush_addr),
        .room_ok    (room_ok),
        .rsp_valid  (mem_rvalid),
        .rsp_word   (mem_rdata),
        .rd_req     (mem_req),
        .rd_addr    (mem_addr),
        .push_kind  (push_kind),
        .push_b0    (push_b0),
        .push_b1    (push_b1)
    );

    ifq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .push_kind (push_kind),
        .push_b0   (push_b0),
        .push_b1   (push_b1),
        .pop_kind  (pop_kind),
        .head0     (head0),
        .head1     (head1),
        .count     (q_count),
        .room_ok   (room_ok)
    );

    ifq_drain #(.DEPTH(DEPTH)) u_drain (
        .pop_req   (pop_req),
        .pop_two   (pop_two),
        .flush     (flush),
        .count     (q_count),
        .pop_ready (pop_ready),
        .pop_kind  (pop_kind)
    );

    // Present the two oldest bytes, oldest in the low half.
    always_comb begin
        pop_data = {head1, head0};
    end

endmodule

// File: rtl/ifq_checker.sv
// Module: ifq_checker
// Port-level properties of the prefetch queue, attached by bind.
// Assumes the port semantics of ifetch_queue.
module ifq_checker #(
    parameter int DEPTH = 6,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          pop_req,
    input logic          pop_two,
    input logic          pop_ready,
    input logic [CW-1:0] q_count,
    input logic          mem_req,
    input logic          mem_rvalid
);

    p_count_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= DEPTH);

    p_req_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> int'(q_count) <= DEPTH - 2);

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> q_count == '0);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !pop_ready && !flush && !mem_rvalid) |=> q_count == $past(q_count));

    p_pushpop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && pop_ready && !flush && !mem_rvalid)
        |=> int'(q_count) == int'($past(q_count)) - ($past(pop_two) ? 2 : 1));

endmodule

bind ifetch_queue ifq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .pop_req    (pop_req),
    .pop_two    (pop_two),
    .pop_ready  (pop_ready),
    .q_count    (q_count),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid)
);

// File: tb/ifetch_queue_tb.sv
// Bench: constrained random plus directed phases, with a byte-address stream model.
module ifetch_queue_tb;

    localparam int          PERIOD = 10;
    localparam int          DEPTH  = 6;
    localparam int          AW     = 16;
    localparam logic [15:0] RVEC   = 16'h0100;
    localparam int          CW     = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [AW-1:0] flush_addr = '0;
    logic          pop_req = 1'b0;
    logic          pop_two = 1'b0;
    logic          pop_ready;
    logic [15:0]   pop_data;
    logic [CW-1:0] q_count;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [15:0]   mem_rdata = '0;

    int checks = 0;
    int errs   = 0;

    // Memory model and expectation state.
    int          lat_cnt = 0;
    logic [15:0] req_addr = '0;
    bit          stale = 0;
    logic [15:0] bpc = RVEC;
    logic [15:0] exp_rd = RVEC;
    int          exp_count = 0;
    bit          have_exp = 0;

    // Phase controls.
    int          pop_pct = 0;
    int          flush_pct = 0;
    bit          force_flush = 0;
    logic [15:0] force_tgt = '0;
    bit          flush_on_busy = 0;
    string       tag = "R5";

    ifetch_queue #(.DEPTH(DEPTH), .AW(AW), .RESET_VEC(RVEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .pop_req(pop_req), .pop_two(pop_two), .pop_ready(pop_ready),
        .pop_data(pop_data), .q_count(q_count), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #(PERIOD / 2) clk = ~clk;

    // Byte stored at a memory address.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // One cycle: called at negedge + 1.
    task automatic step();
        bit          rv;
        bit          fl;
        bit          pr;
        bit          p2;
        bit          acc;
        int          need;
        int          pushn;
        int          lat_before;
        logic [15:0] tgt;

        if (have_exp) chk(int'(q_count) == exp_count, "R11/R7/R8 count", q_count, exp_count);
        chk(int'(q_count) <= DEPTH, "R1 capacity", q_count, DEPTH);

        // Memory responder.
        rv = 0;
        lat_before = lat_cnt;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) rv = 1;
        end
        mem_rvalid = rv;
        mem_rdata  = rv ? {mem_byte(req_addr + 16'd1), mem_byte(req_addr)} : 16'h0;
        if (mem_req) begin
            chk(lat_before == 0, "R3 single outstanding", lat_before, 0);
            chk(int'(q_count) <= DEPTH - 2, "R3 room", q_count, DEPTH - 2);
            chk(mem_addr == {bpc[15:1], 1'b0}, "R3 addr", mem_addr, {bpc[15:1], 1'b0});
            req_addr = mem_addr;
            lat_cnt  = 1 + int'($urandom_range(0, 3));
        end

        // Stimulus.
        tgt = 16'($urandom);
        fl  = 0;
        if (force_flush) begin
            fl  = 1;
            tgt = force_tgt;
        end else if (flush_on_busy) begin
            fl = (lat_cnt > 0) && !mem_req && ($urandom % 2 == 0);
        end else begin
            fl = (int'($urandom % 100) < flush_pct);
        end
        pr = (int'($urandom % 100) < pop_pct);
        p2 = $urandom % 2;
        flush      = fl;
        flush_addr = tgt;
        pop_req    = pr;
        pop_two    = p2;
        #1;

        need = p2 ? 2 : 1;
        chk(pop_ready == (int'(q_count) >= need), "R7 ready", pop_ready, int'(q_count) >= need);
        acc = pr && pop_ready && !fl;
        if (acc) begin
            chk(pop_data[7:0] == mem_byte(exp_rd), {"R6 byte0 ", tag}, pop_data[7:0], mem_byte(exp_rd));
            if (p2)
                chk(pop_data[15:8] == mem_byte(exp_rd + 16'd1), {"R6 byte1 ", tag},
                    pop_data[15:8], mem_byte(exp_rd + 16'd1));
            exp_rd = exp_rd + 16'(need);
        end

        pushn = 0;
        if (rv) begin
            if (!stale && !fl) begin
                pushn = bpc[0] ? 1 : 2;
                bpc   = bpc + 16'(pushn);
            end
            stale = 0;
        end
        exp_count = fl ? 0 : int'(q_count) - (acc ? need : 0) + pushn;
        if (fl) begin
            bpc    = tgt;
            exp_rd = tgt;
            stale  = (lat_cnt > 0) || mem_req;
        end
        have_exp = 1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            step();
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(q_count == '0, "R2 empty after reset", q_count, 0);
        rst_n = 1'b1;
        #1;
        chk(mem_req == 1'b1, "R2 first request", mem_req, 1);
        chk(mem_addr == RVEC, "R2 reset vector", mem_addr, RVEC);
        step();

        // Run ahead with the execute side stalled.
        tag = "R4";
        run(40);
        chk(int'(q_count) == DEPTH, "R4 full", q_count, DEPTH);
        chk(mem_req == 1'b0, "R4 no request when full", mem_req, 0);

        // Redirect to an odd target, then drain.
        @(negedge clk); #1;
        force_flush = 1;
        force_tgt   = 16'h2345;
        step();
        force_flush = 0;
        tag = "R10 odd target";
        pop_pct = 100;
        run(30);

        // Flushes only while a response is outstanding.
        tag = "R9 flush in flight";
        flush_on_busy = 1;
        pop_pct = 50;
        run(300);
        flush_on_busy = 0;

        // Random mixes.
        tag = "R5 random";
        pop_pct = 60;  flush_pct = 3;  run(1500);
        pop_pct = 15;  flush_pct = 2;  run(1000);
        pop_pct = 95;  flush_pct = 4;  run(1000);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule